// File: doc/BRIEF.md
# Channel-Scan Command Generator for a Serial ADC

This block builds the 8-bit command byte that a serial analog-to-digital converter with eight analog inputs expects at the start of each conversion frame. It also produces the 4-bit channel address that goes with the result of that frame. On every frame strobe from the transaction controller it moves to the next input. In single-ended operation it visits the eight inputs one at a time. In differential operation it visits four adjacent input pairs. The scan mode and the power-down setting are sampled on the strobe and encoded into the command.

An active-low start input gates the scan. While start is high, the generator sits at address 0000, which means no channel is selected and no conversion is requested. In that state the command byte is all zeros and the valid flag is low. The address, the command and the valid flag change only on a frame strobe, or when start is released. They stay steady for the whole serial transaction that follows, even if the mode or power-down inputs change during it.

Top module: `scan_cmd_gen`

## Requirements
- R1: An active-low reset puts the address at 0, the command byte at 0x00 and cmd_valid low.
- R2: While cmd_valid is high, command bit 7 (the start marker) is 1 and bit 3 is 0.
- R3: When a strobe samples diff_mode=0, command bit 2 becomes 1. Bits 6:4 become the new address minus one, which selects a single input from 0 to 7. For example, address 1 with power-down code 00 gives 0x84.
- R4: When a strobe samples diff_mode=1, command bit 2 becomes 0. Bits 6:4 become the address minus one, from 000 to 011, which selects pair k made of inputs 2k and 2k+1.
- R5: Command bits 1:0 equal the power-down code sampled by the most recent advancing strobe (00 = sleep between conversions, 11 = stay powered).
- R6: In single-ended mode each strobe advances the address by one, from 1 through 8, and address 8 wraps to 1.
- R7: In differential mode the address runs from 1 through 4. A strobe taken at address 4 or higher moves it to 1.
- R8: Without a strobe, the address, the command and cmd_valid hold their values, whatever diff_mode and pd_sel do.
- R9: With start_n high, the next edge gives address 0, command 0x00 and cmd_valid low, and frame strobes are ignored.
- R10: The first strobe taken from address 0 with start_n low gives address 1.
- R11: cmd_valid is high exactly when the address is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| start_n | input | 1 | Active-low scan enable |
| frame_stb | input | 1 | One-cycle strobe marking the start of a new conversion frame |
| diff_mode | input | 1 | 0 selects single-ended scanning, 1 selects differential pairs |
| pd_sel | input | 2 | Power-down code placed in command bits 1:0 |
| cmd_byte | output | 8 | Command byte for the converter, sent MSB first by the shifter |
| chan_addr | output | 4 | Channel address for the current frame, 0 when idle |
| cmd_valid | output | 1 | High while a channel is selected |

## Verification
The assertions assume that frame_stb is a synchronous single-cycle pulse. They also assume that diff_mode and pd_sel are settled at the edge on which a strobe is taken. No assumption is made about those inputs between strobes. The bench drives every input on the falling clock edge, so each strobe samples stable values. It changes mode and power-down code freely on cycles without a strobe, to show that those changes do not reach the outputs.

// File: rtl/scan_cmd_pkg.sv
package scan_cmd_pkg;

   typedef enum logic {
      MODE_SINGLE = 1'b0,
      MODE_DIFF   = 1'b1
   } in_mode_e;

   localparam logic CMD_START_MARK = 1'b1;
   localparam logic CMD_SPARE_BIT  = 1'b0;

endpackage

// File: rtl/scan_seq_fsm.sv
module scan_seq_fsm
   import scan_cmd_pkg::*;
#(
   parameter int NUM_INPUTS = 8,
   parameter int ADDR_W     = 4,
   parameter int PD_W       = 2,
   parameter bit ASYNC_RST  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_n,
   input  logic              frame_stb,
   input  logic              mode_diff,
   input  logic [PD_W-1:0]   pd_sel,
   output logic [ADDR_W-1:0] addr_q,
   output in_mode_e          mode_q,
   output logic [PD_W-1:0]   pd_q,
   output logic              valid_q
);

   localparam int NUM_PAIRS = NUM_INPUTS / 2;
   localparam logic [ADDR_W-1:0] LAST_SINGLE = ADDR_W'(NUM_INPUTS);
   localparam logic [ADDR_W-1:0] LAST_DIFF   = ADDR_W'(NUM_PAIRS);
   localparam logic [ADDR_W-1:0] FIRST_ADDR  = ADDR_W'(1);

   generate
      if (NUM_INPUTS < 2 || (NUM_INPUTS % 2) != 0) begin : g_bad_inputs
         $error("scan_seq_fsm: NUM_INPUTS must be even and at least 2");
      end
      if (NUM_INPUTS >= (1 << ADDR_W)) begin : g_bad_addr
         $error("scan_seq_fsm: ADDR_W too narrow for NUM_INPUTS");
      end
      if (PD_W < 1) begin : g_bad_pd
         $error("scan_seq_fsm: PD_W must be at least 1");
      end
   endgenerate

   logic [ADDR_W-1:0] addr_d;
   in_mode_e          mode_d;
   logic [PD_W-1:0]   pd_d;
   logic              valid_d;
   logic [ADDR_W-1:0] last_addr;
   in_mode_e          mode_in;

   assign mode_in   = mode_diff ? MODE_DIFF : MODE_SINGLE;
   assign last_addr = (mode_in == MODE_DIFF) ? LAST_DIFF : LAST_SINGLE;

   // next-state and output process
   always_comb begin
      addr_d  = addr_q;
      mode_d  = mode_q;
      pd_d    = pd_q;
      valid_d = valid_q;
      if (start_n) begin
         addr_d  = '0;
         mode_d  = MODE_SINGLE;
         pd_d    = '0;
         valid_d = 1'b0;
      end else if (frame_stb) begin
         if (addr_q == '0 || addr_q >= last_addr) begin
            addr_d = FIRST_ADDR;
         end else begin
            addr_d = addr_q + FIRST_ADDR;
         end
         mode_d  = mode_in;
         pd_d    = pd_sel;
         valid_d = 1'b1;
      end
   end

   // state process, reset style chosen by parameter
   generate
      if (ASYNC_RST) begin : g_async
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               addr_q  <= '0;
               mode_q  <= MODE_SINGLE;
               pd_q    <= '0;
               valid_q <= 1'b0;
            end else begin
               addr_q  <= addr_d;
               mode_q  <= mode_d;
               pd_q    <= pd_d;
               valid_q <= valid_d;
            end
         end
      end else begin : g_sync
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               addr_q  <= '0;
               mode_q  <= MODE_SINGLE;
               pd_q    <= '0;
               valid_q <= 1'b0;
            end else begin
               addr_q  <= addr_d;
               mode_q  <= mode_d;
               pd_q    <= pd_d;
               valid_q <= valid_d;
            end
         end
      end
   endgenerate

   AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      addr_q <= LAST_SINGLE);                                      // R6

   AST_DIFF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_DIFF) |-> (addr_q <= LAST_DIFF));           // R7

   AST_SINGLE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_n && frame_stb && !mode_diff && addr_q == LAST_SINGLE)
      |=> (addr_q == FIRST_ADDR));                                 // R6

   AST_DIFF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_n && frame_stb && mode_diff && addr_q >= LAST_DIFF)
      |=> (addr_q == FIRST_ADDR));                                 // R7

   AST_HOLD_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_n && !frame_stb) |=> $stable(addr_q) && $stable(valid_q)); // R8

   AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start_n |=> (addr_q == '0) && !valid_q);                     // R9

   AST_FIRST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_n && frame_stb && addr_q == '0) |=> (addr_q == FIRST_ADDR)); // R10

endmodule

// File: rtl/scan_cmd_encode.sv
module scan_cmd_encode
   import scan_cmd_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int SEL_W  = 3,
   parameter int PD_W   = 2,
   parameter int CMD_W  = 1 + SEL_W + 2 + PD_W
) (
   input  logic [ADDR_W-1:0] addr,
   input  in_mode_e          mode,
   input  logic [PD_W-1:0]   pd,
   input  logic              valid,
   output logic [CMD_W-1:0]  cmd
);

   generate
      if (CMD_W != 1 + SEL_W + 2 + PD_W) begin : g_bad_cmd
         $error("scan_cmd_encode: CMD_W does not match field widths");
      end
      if (SEL_W > ADDR_W) begin : g_bad_sel
         $error("scan_cmd_encode: SEL_W wider than ADDR_W");
      end
   endgenerate

   logic [ADDR_W-1:0] index;
   logic [SEL_W-1:0]  sel;
   logic              single_bit;

   assign index      = addr - ADDR_W'(1);
   assign sel        = index[SEL_W-1:0];
   assign single_bit = (mode == MODE_SINGLE);

   always_comb begin
      if (valid) begin
         cmd = {CMD_START_MARK, sel, CMD_SPARE_BIT, single_bit, pd};
      end else begin
         cmd = '0;
      end
   end

endmodule

// File: rtl/scan_cmd_gen.sv
module scan_cmd_gen
   import scan_cmd_pkg::*;
#(
   parameter int NUM_INPUTS = 8,
   parameter int ADDR_W     = 4,
   parameter int PD_W       = 2,
   parameter bit ASYNC_RST  = 1'b1,
   parameter int SEL_W      = $clog2(NUM_INPUTS),
   parameter int CMD_W      = 1 + SEL_W + 2 + PD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_n,
   input  logic              frame_stb,
   input  logic              diff_mode,
   input  logic [PD_W-1:0]   pd_sel,
   output logic [CMD_W-1:0]  cmd_byte,
   output logic [ADDR_W-1:0] chan_addr,
   output logic              cmd_valid
);

   localparam int BIT_START = CMD_W - 1;
   localparam int BIT_SPARE = PD_W + 1;
   localparam int BIT_SGL   = PD_W;

   generate
      if ((1 << SEL_W) != NUM_INPUTS) begin : g_bad_pow2
         $error("scan_cmd_gen: NUM_INPUTS must be a power of two");
      end
   endgenerate

   logic [ADDR_W-1:0] addr_q;
   in_mode_e          mode_q;
   logic [PD_W-1:0]   pd_q;
   logic              valid_q;

   scan_seq_fsm #(
      .NUM_INPUTS (NUM_INPUTS),
      .ADDR_W     (ADDR_W),
      .PD_W       (PD_W),
      .ASYNC_RST  (ASYNC_RST)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_n   (start_n),
      .frame_stb (frame_stb),
      .mode_diff (diff_mode),
      .pd_sel    (pd_sel),
      .addr_q    (addr_q),
      .mode_q    (mode_q),
      .pd_q      (pd_q),
      .valid_q   (valid_q)
   );

   scan_cmd_encode #(
      .ADDR_W (ADDR_W),
      .SEL_W  (SEL_W),
      .PD_W   (PD_W),
      .CMD_W  (CMD_W)
   ) u_enc (
      .addr  (addr_q),
      .mode  (mode_q),
      .pd    (pd_q),
      .valid (valid_q),
      .cmd   (cmd_byte)
   );

   assign chan_addr = addr_q;
   assign cmd_valid = valid_q;

   AST_CMD_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (cmd_byte[BIT_START] == 1'b1) && (cmd_byte[BIT_SPARE] == 1'b0)); // R2

   AST_SINGLE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_n && frame_stb && !diff_mode) |=> (cmd_byte[BIT_SGL] == 1'b1)); // R3

   AST_DIFF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_n && frame_stb && diff_mode) |=> (cmd_byte[BIT_SGL] == 1'b0)); // R4

   AST_PD_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_n && frame_stb) |=> (cmd_byte[PD_W-1:0] == $past(pd_sel))); // R5

   AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_n && !frame_stb) |=> $stable(cmd_byte));             // R8

   AST_IDLE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |-> (cmd_byte == '0));                            // R9

   AST_VALID_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid == (chan_addr != '0));                             // R11

endmodule

// File: tb/scan_cmd_gen_test.sv
module scan_cmd_gen_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_n = 1'b1;
   logic       frame_stb = 1'b0;
   logic       diff_mode = 1'b0;
   logic [1:0] pd_sel = 2'b00;
   logic [7:0] cmd_byte;
   logic [3:0] chan_addr;
   logic       cmd_valid;

   int n_checks = 0;
   int n_fails  = 0;
   int cycles   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   scan_cmd_gen uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_n   (start_n),
      .frame_stb (frame_stb),
      .diff_mode (diff_mode),
      .pd_sel    (pd_sel),
      .cmd_byte  (cmd_byte),
      .chan_addr (chan_addr),
      .cmd_valid (cmd_valid)
   );

   // vector: {start_n, frame_stb, diff_mode, pd_sel[1:0], exp_addr[3:0], exp_cmd[7:0], exp_valid}
   localparam int NVEC = 23;
   localparam logic [17:0] VEC [NVEC] = '{
      {1'b0, 1'b1, 1'b0, 2'b00, 4'd1, 8'h84, 1'b1},  // 0  first step
      {1'b0, 1'b0, 1'b1, 2'b11, 4'd1, 8'h84, 1'b1},  // 1  hold
      {1'b0, 1'b1, 1'b0, 2'b00, 4'd2, 8'h94, 1'b1},  // 2
      {1'b0, 1'b1, 1'b0, 2'b00, 4'd3, 8'hA4, 1'b1},  // 3
      {1'b0, 1'b1, 1'b0, 2'b00, 4'd4, 8'hB4, 1'b1},  // 4
      {1'b0, 1'b1, 1'b0, 2'b00, 4'd5, 8'hC4, 1'b1},  // 5
      {1'b0, 1'b1, 1'b0, 2'b00, 4'd6, 8'hD4, 1'b1},  // 6
      {1'b0, 1'b1, 1'b0, 2'b00, 4'd7, 8'hE4, 1'b1},  // 7
      {1'b0, 1'b1, 1'b0, 2'b00, 4'd8, 8'hF4, 1'b1},  // 8
      {1'b0, 1'b1, 1'b0, 2'b11, 4'd1, 8'h87, 1'b1},  // 9  wrap 8->1
      {1'b0, 1'b1, 1'b1, 2'b00, 4'd2, 8'h90, 1'b1},  // 10 diff
      {1'b0, 1'b1, 1'b1, 2'b00, 4'd3, 8'hA0, 1'b1},  // 11
      {1'b0, 1'b1, 1'b1, 2'b00, 4'd4, 8'hB0, 1'b1},  // 12
      {1'b0, 1'b1, 1'b1, 2'b00, 4'd1, 8'h80, 1'b1},  // 13 wrap 4->1
      {1'b0, 1'b1, 1'b1, 2'b11, 4'd2, 8'h93, 1'b1},  // 14 pd code
      {1'b0, 1'b1, 1'b0, 2'b00, 4'd3, 8'hA4, 1'b1},  // 15 back to single
      {1'b0, 1'b1, 1'b0, 2'b00, 4'd4, 8'hB4, 1'b1},  // 16
      {1'b0, 1'b1, 1'b0, 2'b00, 4'd5, 8'hC4, 1'b1},  // 17
      {1'b0, 1'b1, 1'b1, 2'b00, 4'd1, 8'h80, 1'b1},  // 18 diff above 4 -> 1
      {1'b1, 1'b1, 1'b0, 2'b11, 4'd0, 8'h00, 1'b0},  // 19 stop
      {1'b1, 1'b1, 1'b1, 2'b11, 4'd0, 8'h00, 1'b0},  // 20 strobe ignored
      {1'b0, 1'b0, 1'b0, 2'b11, 4'd0, 8'h00, 1'b0},  // 21 enabled, no strobe
      {1'b0, 1'b1, 1'b0, 2'b11, 4'd1, 8'h87, 1'b1}   // 22 restart
   };

   function automatic string vec_tag(int i);
      if (i == 0 || i == 22) return "R10";
      if (i == 1 || i == 21) return "R8";
      if (i <= 9)            return "R6";
      if (i <= 12)           return "R4";
      if (i == 13 || i == 18) return "R7";
      if (i == 14)           return "R5";
      if (i <= 17)           return "R3";
      return "R9";
   endfunction

   task automatic check_out(string tag, logic [3:0] ea, logic [7:0] ec, logic ev);
      n_checks++;
      if (chan_addr !== ea || cmd_byte !== ec || cmd_valid !== ev) begin
         n_fails++;
         $display("FAIL %s: addr=%0d cmd=%02h valid=%0b expected addr=%0d cmd=%02h valid=%0b",
                  tag, chan_addr, cmd_byte, cmd_valid, ea, ec, ev);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 5000) begin
         n_fails++;
         $display("FAIL watchdog: cycles=%0d expected below 5000", cycles);
         finish_run();
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check_out("R1", 4'd0, 8'h00, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check_out("R9", 4'd0, 8'h00, 1'b0);

      for (int i = 0; i < NVEC; i++) begin
         start_n   = VEC[i][17];
         frame_stb = VEC[i][16];
         diff_mode = VEC[i][15];
         pd_sel    = VEC[i][14:13];
         @(negedge clk);
         check_out(vec_tag(i), VEC[i][12:9], VEC[i][8:1], VEC[i][0]);
         // R2: frame bits of an active command
         if (cmd_valid) begin
            n_checks++;
            if (cmd_byte[7] !== 1'b1 || cmd_byte[3] !== 1'b0) begin
               n_fails++;
               $display("FAIL R2: cmd=%02h expected bit7=1 bit3=0", cmd_byte);
            end
         end
         // R11: valid tracks nonzero address
         n_checks++;
         if (cmd_valid !== (chan_addr != 4'd0)) begin
            n_fails++;
            $display("FAIL R11: valid=%0b expected %0b", cmd_valid, (chan_addr != 4'd0));
         end
      end

      // R8: several idle cycles with toggling mode/pd leave outputs fixed
      frame_stb = 1'b0;
      for (int k = 0; k < 4; k++) begin
         diff_mode = k[0];
         pd_sel    = k[1:0];
         @(negedge clk);
      end
      check_out("R8", 4'd1, 8'h87, 1'b1);

      // R1: reset in the middle of a scan
      rst_n = 1'b0;
      @(negedge clk);
      check_out("R1", 4'd0, 8'h00, 1'b0);
      rst_n = 1'b1;

      // R10 + R4: first strobe in differential mode
      frame_stb = 1'b1;
      diff_mode = 1'b1;
      pd_sel    = 2'b00;
      @(negedge clk);
      check_out("R10", 4'd1, 8'h80, 1'b1);
      frame_stb = 1'b0;
      @(negedge clk);
      finish_run();
   end

endmodule